// File: doc/BRIEF.md
# Multi-format pixel input demultiplexer

This block sits at the pixel input of a video encoder. Each input clock it samples a data bus of up to 16 bits. A 4-bit format code tells it how the bus is laid out. The block rebuilds one complete pixel from one, two or three of these transfers. RGB values with 5-bit or 6-bit channels are widened to 8 bits per channel. For 4:2:2 YCbCr input, every group of four components is turned into two pixels that share the same chroma pair. Each finished pixel comes out as a 24-bit word with a one-cycle valid strobe and a flag that says whether the word holds RGB or YCbCr.

A start-of-line pulse puts the transfer phase back to the first transfer of a pixel, or to the Cb slot for the YCbCr formats. A source that loses step, or starts mid-pixel, is therefore realigned at the next line. Format codes above 9 are reserved and produce no output.

Top module: `pix_demux`

## Requirements
- R1: While reset is held, pix_valid_o stays 0 and pix_o reads 0 on the first cycle after reset.
- R2: Format 0 and format 3 turn every transfer into one pixel. In format 0, R=bus[15:11], G=bus[10:5] and B=bus[4:0]. In format 3, R=bus[14:10], G=bus[9:5] and B=bus[4:0], and bus[15] is ignored. A 5-bit channel v is widened to {v, v[4:2]} and a 6-bit channel v to {v, v[5:4]}.
- R3: Format 2 takes two 16-bit words. The first holds {R,G} in bits [15:8],[7:0]. The second holds B in bits [15:8], and its bits [7:0] are ignored.
- R4: Formats 4 and 5 take two transfers in bus[11:0], and bus[15:12] is ignored. In format 4 the first transfer is {G[3:0],B[7:0]} and the second is {R[7:0],G[7:4]}. In format 5 the first is {R[7:0],G[7:4]} and the second is {G[3:0],B[7:0]}.
- R5: Format 6 takes three bytes on bus[7:0] in the order R, G, B. Bus[15:8] is ignored.
- R6: Formats 7 and 8 take two bytes on bus[7:0]. The first byte is the upper half and the second byte is the lower half of a 16-bit word. That word is laid out as in format 0 (for format 7) or as in format 3 (for format 8).
- R7: Format 1 takes the words {Cb,Y0} and then {Cr,Y1}, with the first-named component in bits [15:8]. Two pixels result: (Y0,Cb,Cr) on the cycle after the second word, and (Y1,Cb,Cr) on the following cycle, provided the format code is still 1 in that cycle.
- R8: Format 9 takes bytes on bus[7:0] in the order Cb, Y0, Cr, Y1. It outputs (Y0,Cb,Cr) after the Cr byte and (Y1,Cb,Cr) after the Y1 byte.
- R9: An RGB pixel is output as pix_o={R,G,B} with pix_ycc_o=0. A YCbCr pixel is output as pix_o={Y,Cb,Cr} with pix_ycc_o=1.
- R10: A transfer sampled while sol_i is 1 is taken as the first transfer of a pixel (Cb for YCbCr). A second YCbCr pixel that is already waiting is still output in that cycle.
- R11: While the format code is 10 to 15, pix_valid_o is 0 on the cycle after each sample.
- R12: A pixel appears on the outputs, with pix_valid_o=1, on the cycle right after its last transfer is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_i | input | 4 | Input format code, 0 to 9 (10 to 15 reserved) |
| sol_i | input | 1 | Start-of-line pulse, marks the current transfer as the first of a pixel |
| bus_i | input | 16 | Pixel data bus, sampled every clock |
| pix_o | output | 24 | Reassembled pixel, {R,G,B} or {Y,Cb,Cr} |
| pix_valid_o | output | 1 | One-cycle strobe for each pixel |
| pix_ycc_o | output | 1 | 1 when pix_o holds YCbCr |

## Verification
In format 1, the second pixel of a pair is output in the same cycle that the next pair's Cb word arrives. When that word also carries the start-of-line pulse, phase realignment and the release of the waiting pixel happen at once. The bench sends back-to-back format-1 pairs with sol_i on every first word, and sends misaligned partial pixels followed by a realigning pulse. The scoreboard then requires every queued pixel, including each waiting second pixel, to appear in order with the right YCbCr flag, and no extra pixel from the discarded transfers.

// File: rtl/pix_demux_pkg.sv
// Shared constants, format codes and channel widening helpers for the
// pixel input demultiplexer. Assumes 8-bit output channels.
package pix_demux_pkg;
    localparam int FMT_W = 4;
    localparam int BUS_W = 16;
    localparam int CH_W  = 8;
    localparam int PIX_W = 3 * CH_W;
    localparam int NSLOT = 3;
    localparam int PH_W  = 2;
    localparam int NFMT  = 10;

    typedef enum logic [FMT_W-1:0] {
        FMT_RGB565_W  = 4'd0,
        FMT_YCC_W     = 4'd1,
        FMT_RGB24_W2  = 4'd2,
        FMT_RGB555_W  = 4'd3,
        FMT_RGB24_N12A = 4'd4,
        FMT_RGB24_N12B = 4'd5,
        FMT_RGB24_B3  = 4'd6,
        FMT_RGB565_B2 = 4'd7,
        FMT_RGB555_B2 = 4'd8,
        FMT_YCC_B     = 4'd9
    } fmt_e;

    // Index of the final transfer of one pixel group for a format code
    function automatic logic [PH_W-1:0] last_phase(input logic [FMT_W-1:0] f);
        case (f)
            FMT_RGB565_W, FMT_RGB555_W: return 2'd0;
            FMT_RGB24_B3:               return 2'd2;
            FMT_YCC_B:                  return 2'd3;
            FMT_YCC_W, FMT_RGB24_W2, FMT_RGB24_N12A,
            FMT_RGB24_N12B, FMT_RGB565_B2, FMT_RGB555_B2: return 2'd1;
            default:                    return 2'd0;
        endcase
    endfunction

    function automatic logic is_reserved(input logic [FMT_W-1:0] f);
        return f >= FMT_W'(NFMT);
    endfunction

    // Widen a 5-bit channel by repeating its top bits
    function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    // Widen a 6-bit channel by repeating its top bits
    function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction
endpackage

// File: rtl/pix_phase_ctr.sv
// Transfer phase counter. Tracks which transfer of a pixel group the
// current bus sample is. sol_i forces the current sample to phase 0.
// A stored phase beyond the format's last one (after a format change) is
// treated as phase 0. Reserved formats hold the counter at 0.
module pix_phase_ctr
    import pix_demux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt_i,
    input  logic             sol_i,
    output logic [PH_W-1:0]  cur_o
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] last;
    logic            rsvd;

    // Decode the group length and apply the start-of-line override
    always_comb begin
        last  = last_phase(fmt_i);
        rsvd  = is_reserved(fmt_i);
        cur_o = (sol_i || phase_q > last) ? '0 : phase_q;
    end

    // Advance the phase, wrapping after the last transfer of a group
    always_ff @(posedge clk) begin
        if (!rst_n)             phase_q <= '0;
        else if (rsvd)          phase_q <= '0;
        else if (cur_o == last) phase_q <= '0;
        else                    phase_q <= cur_o + PH_W'(1);
    end

    assert_sol_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sol_i && !rsvd && last != '0) |=> (phase_q == PH_W'(1)));
    assert_phase_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd |=> (phase_q == '0));
endmodule

// File: rtl/pix_capture.sv
// Holds the earlier transfers of a pixel group. Slot 0 keeps a full bus
// word (the 16-bit two-word formats need all of it); later slots are only
// used by byte formats and keep the low byte. Slot s loads when the current
// phase equals s.
module pix_capture
    import pix_demux_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PH_W-1:0]            cur_i,
    input  logic [BUS_W-1:0]           bus_i,
    output logic [BUS_W-1:0]           cap_full_o,
    output logic [NSLOT-1:1][CH_W-1:0] cap_byte_o
);
    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            if (s == 0) begin : g_word
                // Load the full first word of a group
                always_ff @(posedge clk) begin
                    if (!rst_n)           cap_full_o <= '0;
                    else if (cur_i == '0) cap_full_o <= bus_i;
                end
            end else begin : g_byte
                // Load the low byte of a later transfer
                always_ff @(posedge clk) begin
                    if (!rst_n)                    cap_byte_o[s] <= '0;
                    else if (cur_i == PH_W'(s))    cap_byte_o[s] <= bus_i[CH_W-1:0];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pix_assemble.sv
// Combinational pixel assembly. Given the format, the current phase, the
// stored earlier transfers and the live bus, reports whether a pixel is
// complete this cycle and builds it. For the 16-bit YCbCr format it also
// builds the second pixel of the pair, which the caller outputs next cycle.
module pix_assemble
    import pix_demux_pkg::*;
(
    input  logic [FMT_W-1:0]           fmt_i,
    input  logic [PH_W-1:0]            cur_i,
    input  logic [BUS_W-1:0]           cap_full_i,
    input  logic [NSLOT-1:1][CH_W-1:0] cap_byte_i,
    input  logic [BUS_W-1:0]           bus_i,
    output logic                       done_o,
    output logic [PIX_W-1:0]           pix_o,
    output logic                       ycc_o,
    output logic                       alt_req_o,
    output logic [PIX_W-1:0]           alt_pix_o
);
    logic [BUS_W-1:0] pair_w;

    // Rebuild a 16-bit word from two successive bytes
    assign pair_w = {cap_full_i[CH_W-1:0], bus_i[CH_W-1:0]};

    // Select the layout for the format and phase
    always_comb begin
        done_o    = 1'b0;
        ycc_o     = 1'b0;
        alt_req_o = 1'b0;
        pix_o     = '0;
        alt_pix_o = '0;
        case (fmt_i)
            FMT_RGB565_W: begin
                done_o = 1'b1;
                pix_o  = {widen5(bus_i[15:11]), widen6(bus_i[10:5]), widen5(bus_i[4:0])};
            end
            FMT_RGB555_W: begin
                done_o = 1'b1;
                pix_o  = {widen5(bus_i[14:10]), widen5(bus_i[9:5]), widen5(bus_i[4:0])};
            end
            FMT_YCC_W: if (cur_i == 2'd1) begin
                done_o    = 1'b1;
                ycc_o     = 1'b1;
                pix_o     = {cap_full_i[7:0], cap_full_i[15:8], bus_i[15:8]};
                alt_req_o = 1'b1;
                alt_pix_o = {bus_i[7:0], cap_full_i[15:8], bus_i[15:8]};
            end
            FMT_RGB24_W2: if (cur_i == 2'd1) begin
                done_o = 1'b1;
                pix_o  = {cap_full_i[15:8], cap_full_i[7:0], bus_i[15:8]};
            end
            FMT_RGB24_N12A: if (cur_i == 2'd1) begin
                done_o = 1'b1;
                pix_o  = {bus_i[11:4], bus_i[3:0], cap_full_i[11:8], cap_full_i[7:0]};
            end
            FMT_RGB24_N12B: if (cur_i == 2'd1) begin
                done_o = 1'b1;
                pix_o  = {cap_full_i[11:4], cap_full_i[3:0], bus_i[11:8], bus_i[7:0]};
            end
            FMT_RGB24_B3: if (cur_i == 2'd2) begin
                done_o = 1'b1;
                pix_o  = {cap_full_i[7:0], cap_byte_i[1], bus_i[7:0]};
            end
            FMT_RGB565_B2: if (cur_i == 2'd1) begin
                done_o = 1'b1;
                pix_o  = {widen5(pair_w[15:11]), widen6(pair_w[10:5]), widen5(pair_w[4:0])};
            end
            FMT_RGB555_B2: if (cur_i == 2'd1) begin
                done_o = 1'b1;
                pix_o  = {widen5(pair_w[14:10]), widen5(pair_w[9:5]), widen5(pair_w[4:0])};
            end
            FMT_YCC_B: begin
                if (cur_i == 2'd2) begin
                    done_o = 1'b1;
                    ycc_o  = 1'b1;
                    pix_o  = {cap_byte_i[1], cap_full_i[7:0], bus_i[7:0]};
                end else if (cur_i == 2'd3) begin
                    done_o = 1'b1;
                    ycc_o  = 1'b1;
                    pix_o  = {bus_i[7:0], cap_full_i[7:0], cap_byte_i[2]};
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pix_demux.sv
// Multi-format pixel input demultiplexer, top level. Samples the bus every
// clock and outputs one registered 24-bit pixel per completed group, plus
// the waiting second pixel of a 16-bit YCbCr pair on the following cycle.
// Assumes a transfer on every clock; sol_i realigns the group phase.
module pix_demux
    import pix_demux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       fmt_i,
    input  logic             sol_i,
    input  logic [15:0]      bus_i,
    output logic [23:0]      pix_o,
    output logic             pix_valid_o,
    output logic             pix_ycc_o
);
    logic [PH_W-1:0]            cur;
    logic [BUS_W-1:0]           cap_full;
    logic [NSLOT-1:1][CH_W-1:0] cap_byte;
    logic                       asm_done, asm_ycc, asm_alt_req;
    logic [PIX_W-1:0]           asm_pix, asm_alt_pix;
    logic                       alt_pend_q;
    logic [PIX_W-1:0]           alt_pix_q;

    pix_phase_ctr u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .fmt_i (fmt_i),
        .sol_i (sol_i),
        .cur_o (cur)
    );

    pix_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_i      (cur),
        .bus_i      (bus_i),
        .cap_full_o (cap_full),
        .cap_byte_o (cap_byte)
    );

    pix_assemble u_asm (
        .fmt_i      (fmt_i),
        .cur_i      (cur),
        .cap_full_i (cap_full),
        .cap_byte_i (cap_byte),
        .bus_i      (bus_i),
        .done_o     (asm_done),
        .pix_o      (asm_pix),
        .ycc_o      (asm_ycc),
        .alt_req_o  (asm_alt_req),
        .alt_pix_o  (asm_alt_pix)
    );

    // Register the finished pixel, or release the waiting second YCbCr pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o       <= '0;
            pix_valid_o <= 1'b0;
            pix_ycc_o   <= 1'b0;
            alt_pend_q  <= 1'b0;
            alt_pix_q   <= '0;
        end else if (asm_done) begin
            pix_o       <= asm_pix;
            pix_valid_o <= 1'b1;
            pix_ycc_o   <= asm_ycc;
            alt_pend_q  <= asm_alt_req;
            alt_pix_q   <= asm_alt_pix;
        end else if (alt_pend_q && fmt_i == FMT_YCC_W) begin
            pix_o       <= alt_pix_q;
            pix_valid_o <= 1'b1;
            pix_ycc_o   <= 1'b1;
            alt_pend_q  <= 1'b0;
        end else begin
            pix_valid_o <= 1'b0;
            alt_pend_q  <= 1'b0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !pix_valid_o);
    assert_single_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i == FMT_RGB565_W || fmt_i == FMT_RGB555_W) |=> pix_valid_o);
    assert_second_ycc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_pend_q && fmt_i == FMT_YCC_W) |=> (pix_valid_o && pix_ycc_o));
    assert_flag_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> (pix_ycc_o == ($past(fmt_i) == FMT_YCC_W || $past(fmt_i) == FMT_YCC_B)));
    assert_reserved_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_reserved(fmt_i) |=> !pix_valid_o);
    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        asm_done |=> pix_valid_o);
endmodule

// File: tb/tb_pix_demux.sv
`timescale 1ns/1ps
module tb_pix_demux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fmt = 4'hF;
    logic        sol = 1'b0;
    logic [15:0] bus = '0;
    logic [23:0] pix_o;
    logic        pix_valid_o, pix_ycc_o;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";
    logic [24:0] expq[$];

    always #2 clk = ~clk;

    pix_demux dut (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .sol_i(sol), .bus_i(bus),
        .pix_o(pix_o), .pix_valid_o(pix_valid_o), .pix_ycc_o(pix_ycc_o)
    );

    function automatic logic [7:0] w5(input logic [4:0] v); return {v, v[4:2]}; endfunction
    function automatic logic [7:0] w6(input logic [5:0] v); return {v, v[5:4]}; endfunction

    task automatic check(input logic ok, input string req, input logic [24:0] act, input logic [24:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare every output pixel in order
    always @(negedge clk) begin
        if (rst_n && pix_valid_o) begin
            if (expq.size() == 0) begin
                check(1'b0, {cur_req, " unexpected pixel"}, {pix_ycc_o, pix_o}, 25'h0);
            end else begin
                logic [24:0] e;
                e = expq.pop_front();
                check({pix_ycc_o, pix_o} == e, cur_req, {pix_ycc_o, pix_o}, e);
            end
        end
    end

    task automatic xfer(input logic [3:0] f, input logic [15:0] d, input logic s);
        @(negedge clk);
        fmt = f; bus = d; sol = s;
    endtask

    task automatic gap(input int n);
        repeat (n) begin
            @(negedge clk);
            fmt = 4'hF; sol = 1'b0; bus = 16'hDEAD;
        end
    endtask

    // Driver: push the expected RGB pixel and send its transfers
    task automatic put_rgb(input logic [3:0] f, input logic [7:0] r, input logic [7:0] g,
                           input logic [7:0] b, input logic s);
        logic [15:0] w;
        case (f)
            4'd0, 4'd7: begin
                expq.push_back({1'b0, w5(r[7:3]), w6(g[7:2]), w5(b[7:3])});
                w = {r[7:3], g[7:2], b[7:3]};
            end
            4'd3, 4'd8: begin
                expq.push_back({1'b0, w5(r[7:3]), w5(g[7:3]), w5(b[7:3])});
                w = {1'b1, r[7:3], g[7:3], b[7:3]};
            end
            default: begin
                expq.push_back({1'b0, r, g, b});
                w = '0;
            end
        endcase
        case (f)
            4'd0, 4'd3: xfer(f, w, s);
            4'd2: begin xfer(f, {r, g}, s); xfer(f, {b, 8'hA5}, 1'b0); end
            4'd4: begin xfer(f, {4'hC, g[3:0], b}, s); xfer(f, {4'h3, r, g[7:4]}, 1'b0); end
            4'd5: begin xfer(f, {4'hC, r, g[7:4]}, s); xfer(f, {4'h3, g[3:0], b}, 1'b0); end
            4'd6: begin xfer(f, {8'hE7, r}, s); xfer(f, {8'h5A, g}, 1'b0); xfer(f, {8'hFF, b}, 1'b0); end
            default: begin xfer(f, {8'h99, w[15:8]}, s); xfer(f, {8'h66, w[7:0]}, 1'b0); end
        endcase
    endtask

    // Driver: push both expected YCbCr pixels and send the four components
    task automatic put_ycc(input logic [3:0] f, input logic [7:0] cb, input logic [7:0] y0,
                           input logic [7:0] cr, input logic [7:0] y1, input logic s);
        expq.push_back({1'b1, y0, cb, cr});
        expq.push_back({1'b1, y1, cb, cr});
        if (f == 4'd1) begin
            xfer(f, {cb, y0}, s);
            xfer(f, {cr, y1}, 1'b0);
        end else begin
            xfer(f, {8'h11, cb}, s);
            xfer(f, {8'h22, y0}, 1'b0);
            xfer(f, {8'h33, cr}, 1'b0);
            xfer(f, {8'h44, y1}, 1'b0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        bus = 16'hFFFF; fmt = 4'd0;
        repeat (2) @(negedge clk);
        check(pix_valid_o == 1'b0, "R1 valid in reset", {24'h0, pix_valid_o}, 25'h0);
        fmt = 4'hF;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({pix_valid_o, pix_o} == 25'h0, "R1 state after reset", {pix_valid_o, pix_o}, 25'h0);

        cur_req = "R2 R9";
        put_rgb(4'd0, 8'hF8, 8'hFC, 8'hF8, 1'b0);
        put_rgb(4'd0, 8'h08, 8'h84, 8'h40, 1'b0);
        put_rgb(4'd0, 8'h00, 8'h00, 8'h00, 1'b1);
        put_rgb(4'd3, 8'hA8, 8'h50, 8'h18, 1'b0);
        put_rgb(4'd3, 8'hF8, 8'h08, 8'h80, 1'b0);
        gap(3);

        cur_req = "R12";
        put_rgb(4'd0, 8'h90, 8'h24, 8'h68, 1'b0);
        @(negedge clk);
        fmt = 4'hF;
        check(pix_valid_o && pix_o == {w5(5'h12), w6(6'h09), w5(5'h0D)}, "R12 latency",
              {pix_valid_o, pix_o}, {1'b1, w5(5'h12), w6(6'h09), w5(5'h0D)});
        gap(3);

        cur_req = "R3 R9";
        put_rgb(4'd2, 8'h12, 8'h34, 8'h56, 1'b1);
        put_rgb(4'd2, 8'hAB, 8'hCD, 8'hEF, 1'b0);
        gap(3);
        cur_req = "R4";
        put_rgb(4'd4, 8'h1E, 8'hA5, 8'h7C, 1'b1);
        put_rgb(4'd4, 8'hC3, 8'h5A, 8'h01, 1'b0);
        gap(3);
        put_rgb(4'd5, 8'h1E, 8'hA5, 8'h7C, 1'b1);
        put_rgb(4'd5, 8'hFE, 8'h0F, 8'h80, 1'b0);
        gap(3);
        cur_req = "R5";
        put_rgb(4'd6, 8'h01, 8'h02, 8'h03, 1'b1);
        put_rgb(4'd6, 8'hFF, 8'h80, 8'h7F, 1'b0);
        gap(3);
        cur_req = "R6";
        put_rgb(4'd7, 8'hC8, 8'h3C, 8'h90, 1'b1);
        put_rgb(4'd7, 8'h10, 8'hF0, 8'h08, 1'b0);
        gap(3);
        put_rgb(4'd8, 8'hC8, 8'h3C, 8'h90, 1'b1);
        put_rgb(4'd8, 8'h78, 8'hF8, 8'h00, 1'b0);
        gap(3);

        cur_req = "R7";
        put_ycc(4'd1, 8'h80, 8'h10, 8'h70, 8'hEB, 1'b1);
        @(negedge clk);
        fmt = 4'd1; sol = 1'b1; bus = 16'h0000;
        check(pix_valid_o && pix_o == 24'h108070, "R7 first of pair", {pix_valid_o, pix_o}, 25'h1108070);
        @(negedge clk);
        fmt = 4'hF; sol = 1'b0;
        check(pix_valid_o && pix_ycc_o && pix_o == 24'hEB8070, "R7 second of pair",
              {pix_valid_o, pix_o}, 25'h1EB8070);
        gap(3);

        cur_req = "R10 R7";
        put_ycc(4'd1, 8'h11, 8'h22, 8'h33, 8'h44, 1'b1);
        put_ycc(4'd1, 8'h55, 8'h66, 8'h77, 8'h88, 1'b1);
        put_ycc(4'd1, 8'h99, 8'hAA, 8'hBB, 8'hCC, 1'b1);
        xfer(4'd1, 16'h0000, 1'b1);
        gap(3);

        cur_req = "R8";
        put_ycc(4'd9, 8'h80, 8'h10, 8'h7F, 8'hEB, 1'b1);
        put_ycc(4'd9, 8'h01, 8'h02, 8'h03, 8'h04, 1'b0);
        gap(3);

        cur_req = "R10";
        xfer(4'd6, 16'h00AA, 1'b1);
        put_rgb(4'd6, 8'h31, 8'h32, 8'h33, 1'b1);
        gap(3);
        xfer(4'd9, 16'h00AA, 1'b1);
        xfer(4'd9, 16'h00BB, 1'b0);
        put_ycc(4'd9, 8'h40, 8'h50, 8'h60, 8'h70, 1'b1);
        gap(3);
        xfer(4'd1, 16'hAAAA, 1'b1);
        put_ycc(4'd1, 8'hC0, 8'hD0, 8'hE0, 8'hF0, 1'b1);
        xfer(4'd1, 16'h0000, 1'b1);
        gap(3);

        cur_req = "R11";
        for (int f = 10; f < 16; f++) begin
            for (int k = 0; k < 4; k++) begin
                xfer(4'(f), 16'(f * 4099 + k * 257), k[0]);
                @(negedge clk);
                check(pix_valid_o == 1'b0, "R11 reserved format", {24'h0, pix_valid_o}, 25'h0);
            end
        end
        gap(4);

        check(expq.size() == 0, "R12 pixels missing", 25'(expq.size()), 25'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule